// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is the control state machine for a dispenser that sells one item for fifteen cents. A single coin slot reports each deposit as a one-cycle pulse: one line for a nickel, one for a dime. The controller keeps the credit as one of four levels: nothing, five, ten, or fifteen-or-more cents. When the credit reaches the top level it raises the release line for the chute. Overpayment is absorbed, no change is given, and the top level is left only through reset.

Two build-time choices shape the hardware. `ENC_ONEHOT` picks a two-bit binary credit register or a four-bit one-hot register. `MEALY_OUT` picks when the release line rises. The registered style raises it the cycle after the completing coin. The early style raises it combinationally during the cycle in which the completing coin is presented. A pulse on both coin lines in the same cycle is illegal. It is treated as no deposit and latched into a sticky error flag.

Top module: `coin_vend_ctl`

## Requirements
- R1: `rst` is synchronous and active-high. In the cycle after a clock edge with `rst` high, the credit is zero, `release_o` is 0 and `coin_err` is 0.
- R2: A nickel alone (`nickel`=1, `dime`=0) raises the credit by one level: 0→5→10→15 cents.
- R3: A dime alone raises the credit by two levels and saturates at the top: 0→10, 5→15, 10→15.
- R4: In a cycle with neither coin line high, the credit does not change.
- R5: Once the credit has reached fifteen cents, `release_o` is 1 and stays 1 for every later input until reset. Further coins change nothing.
- R6: With `MEALY_OUT`=0, `release_o` is a pure function of the credit register. It first goes high in the cycle after the edge that captured the completing coin.
- R7: With `MEALY_OUT`=1, `release_o` is already high during the cycle in which the completing coin is on the inputs.
- R8: `nickel` and `dime` high together leave the credit unchanged and set `coin_err` from the next cycle on. Only reset clears `coin_err`.
- R9: `ENC_ONEHOT`=0 stores the credit as binary 00/01/10/11 for 0/5/10/15 cents. `ENC_ONEHOT`=1 stores it as 0001/0010/0100/1000 with exactly one bit set. The port behaviour is the same for both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset to zero credit |
| nickel | input | 1 | One-cycle pulse per five-cent coin |
| dime | input | 1 | One-cycle pulse per ten-cent coin |
| release_o | output | 1 | Chute release, high at fifteen cents or more |
| coin_err | output | 1 | Sticky flag set by a simultaneous nickel and dime |

## Verification
With the registered output, each coin's effect on `release_o` and on `coin_err` appears one clock edge after the cycle that presents it. With the early output, `release_o` already reflects the coin in its own cycle, while `coin_err` still lags by one edge. The bench drives all four parameter combinations with the same pulses shortly after a falling edge. For every driven cycle it queues one expected record that holds the early-style release for the new credit and the registered-style release and error for the previous credit. A monitor compares that record one nanosecond after the same falling edge, when the inputs are settled and the last rising edge is complete. Cycles with reset asserted are queued but not compared.

// File: rtl/coin_vend_ctl.sv
module coin_vend_ctl #(
  parameter bit ENC_ONEHOT = 1'b0,
  parameter bit MEALY_OUT  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic nickel,
  input  logic dime,
  output logic release_o,
  output logic coin_err
);
  localparam int SW = ENC_ONEHOT ? 4 : 2;
  localparam logic [SW-1:0] ST_ZERO = SW'(ENC_ONEHOT);

  logic [SW-1:0] st_q, st_d;
  logic n_ok, d_ok, clash, full_q, full_d;

  assign n_ok  = nickel & ~dime;
  assign d_ok  = dime & ~nickel;
  assign clash = nickel & dime;

  generate
    if (ENC_ONEHOT) begin : g_onehot
      logic idle;
      assign idle  = ~n_ok & ~d_ok;
      assign st_d  = {st_q[3] | (st_q[2] & (n_ok | d_ok)) | (st_q[1] & d_ok),
                      (st_q[2] & idle) | (st_q[1] & n_ok) | (st_q[0] & d_ok),
                      (st_q[1] & idle) | (st_q[0] & n_ok),
                      st_q[0] & idle};
      assign full_q = st_q[3];
      assign full_d = st_d[3];
    end else begin : g_binary
      assign st_d  = {st_q[1] | d_ok | (st_q[0] & n_ok),
                      (~st_q[0] & n_ok) | (st_q[0] & ~n_ok) |
                      (st_q[1] & n_ok) | (st_q[1] & d_ok)};
      assign full_q = &st_q;
      assign full_d = &st_d;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_ZERO;
      coin_err <= 1'b0;
    end else begin
      st_q <= st_d;
      if (clash) coin_err <= 1'b1;
    end
  end

  assign release_o = MEALY_OUT ? full_d : full_q;
endmodule

// File: rtl/coin_vend_chk.sv
module coin_vend_chk #(
  parameter bit ENC_ONEHOT = 1'b0,
  parameter bit MEALY_OUT  = 1'b0,
  parameter int SW         = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          nickel,
  input logic          dime,
  input logic          release_o,
  input logic          coin_err,
  input logic [SW-1:0] st
);
  a_r1_err_cleared: assert property (@(posedge clk) rst |=> !coin_err);
  a_r1_release_low: assert property (@(posedge clk) rst |=> !release_o);
  a_r5_release_holds: assert property (@(posedge clk) disable iff (rst)
    release_o |=> release_o);
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    coin_err |=> coin_err);
  a_r8_err_flagged: assert property (@(posedge clk) disable iff (rst)
    (nickel && dime) |=> coin_err);

  generate
    if (MEALY_OUT) begin : g_early
      a_r7_same_cycle: assert property (@(posedge clk) disable iff (rst)
        $rose(release_o) |-> (nickel ^ dime));
    end else begin : g_late
      a_r6_after_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(release_o) |-> $past(nickel || dime));
      a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!nickel && !dime && !release_o) |=> !release_o);
    end
    if (ENC_ONEHOT) begin : g_oh
      a_r9_one_bit: assert property (@(posedge clk) disable iff (rst)
        $countones(st) == 1);
    end
  endgenerate
endmodule

bind coin_vend_ctl coin_vend_chk #(
  .ENC_ONEHOT(ENC_ONEHOT), .MEALY_OUT(MEALY_OUT), .SW(SW)
) u_chk (
  .clk(clk), .rst(rst), .nickel(nickel), .dime(dime),
  .release_o(release_o), .coin_err(coin_err), .st(st_q)
);

// File: tb/sim_coin_vend_ctl.sv
`timescale 1ns/1ps
module sim_coin_vend_ctl;
  typedef struct {
    bit    chk;
    bit    late;
    bit    early;
    bit    err;
    string tag;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1, nickel = 1'b0, dime = 1'b0;
  logic [3:0] rel, err;
  int n_chk = 0, n_fail = 0;
  int credit = 0;
  bit err_m = 1'b0;
  bit done = 1'b0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  // u0 binary/late, u1 one-hot/late, u2 binary/early, u3 one-hot/early (R9)
  coin_vend_ctl #(.ENC_ONEHOT(1'b0), .MEALY_OUT(1'b0)) u0 (.clk(clk), .rst(rst),
    .nickel(nickel), .dime(dime), .release_o(rel[0]), .coin_err(err[0]));
  coin_vend_ctl #(.ENC_ONEHOT(1'b1), .MEALY_OUT(1'b0)) u1 (.clk(clk), .rst(rst),
    .nickel(nickel), .dime(dime), .release_o(rel[1]), .coin_err(err[1]));
  coin_vend_ctl #(.ENC_ONEHOT(1'b0), .MEALY_OUT(1'b1)) u2 (.clk(clk), .rst(rst),
    .nickel(nickel), .dime(dime), .release_o(rel[2]), .coin_err(err[2]));
  coin_vend_ctl #(.ENC_ONEHOT(1'b1), .MEALY_OUT(1'b1)) u3 (.clk(clk), .rst(rst),
    .nickel(nickel), .dime(dime), .release_o(rel[3]), .coin_err(err[3]));

  task automatic step(input bit r, input bit n, input bit d, input string tag);
    exp_t e;
    int nxt;
    @(negedge clk);
    rst = r; nickel = n; dime = d;
    nxt = credit;
    if (n && !d) nxt = (credit + 1 > 3) ? 3 : credit + 1;
    if (d && !n) nxt = (credit + 2 > 3) ? 3 : credit + 2;
    e.chk = !r; e.late = (credit == 3); e.early = (nxt == 3); e.err = err_m; e.tag = tag;
    q.push_back(e);
    if (r) begin credit = 0; err_m = 1'b0; end
    else begin credit = nxt; if (n && d) err_m = 1'b1; end
  endtask

  task automatic cmp(input bit act, input bit expv, input string what, input string tag);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, act, expv, $time);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        if (e.chk) begin
          for (int i = 0; i < 4; i++) begin
            cmp(rel[i], (i < 2) ? e.late : e.early, $sformatf("release u%0d", i), e.tag);
            cmp(err[i], e.err, $sformatf("coin_err u%0d", i), e.tag);
          end
        end
      end
    end
  end

  task automatic do_reset();
    step(1, 0, 0, "R1");
    step(1, 0, 0, "R1");
  endtask

  initial begin : driver
    do_reset();
    step(0, 0, 0, "R1");                 // reset state
    repeat (3) step(0, 0, 0, "R4");      // idle hold
    step(0, 1, 0, "R2");                 // nickel x3
    step(0, 0, 0, "R4");
    step(0, 1, 0, "R2");
    step(0, 1, 0, "R7");
    step(0, 0, 0, "R6");
    step(0, 1, 0, "R5");                 // extra coins absorbed
    step(0, 0, 1, "R5");
    step(0, 1, 1, "R5");
    step(0, 0, 0, "R5");
    do_reset();
    step(0, 0, 0, "R1");
    step(0, 1, 0, "R2");                 // nickel then dime
    step(0, 0, 1, "R3");
    step(0, 0, 0, "R6");
    do_reset();
    step(0, 0, 1, "R3");                 // dime then nickel
    step(0, 0, 0, "R4");
    step(0, 1, 0, "R7");
    step(0, 0, 0, "R6");
    do_reset();
    step(0, 0, 1, "R3");                 // dime dime saturates
    step(0, 0, 1, "R3");
    step(0, 0, 1, "R5");
    step(0, 0, 0, "R5");
    do_reset();
    step(0, 1, 1, "R8");                 // illegal pair is no coin
    step(0, 0, 0, "R8");
    step(0, 1, 0, "R8");
    step(0, 1, 1, "R8");
    step(0, 1, 0, "R8");
    step(0, 1, 0, "R8");
    step(0, 0, 0, "R8");
    do_reset();
    step(0, 0, 0, "R1");                 // reset clears error
    step(0, 0, 0, "R1");
    @(negedge clk);
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule